// File: doc/BRIEF.md
# Instruction Prefetch Queue with Redirect Flush

This block keeps an execution pipeline supplied with instruction words by fetching ahead of it. It walks a word-addressed instruction memory one address at a time, each instruction being exactly one word, and parks the returned words in an eight-entry queue. The consumer takes words from the head of the queue, and each one arrives with the address it was fetched from. Fetching and consumption overlap, so while the consumer works on the word at address X, the words from X+1 up to X+7 can already be waiting.

When the consumer takes a jump it drives a redirect with the new target. Every queued word becomes stale at once: the queue is emptied in a single cycle and fetching starts again at the target. Memory responses to requests issued before the redirect are thrown away when they come back. Each request carries an epoch bit that flips on every redirect, and a count of requests left over from before the redirect guards against epochs that repeat. The memory accepts one request per cycle and answers in issue order after any latency of one cycle or more. The consumer port is valid/ready. While `cons_ready` is low the head word and its address hold still. `cons_valid` never rises in a cycle where a redirect is present.

Top module: `insn_prefetch_q`

## Requirements
- R1: During and after reset the queue is empty (`cons_valid` low), the epoch bit is 0, and the first request goes out on the first cycle after reset at address `RESET_VEC`.
- R2: Every request address is the previous request address plus one unless a redirect came in between.
- R3: Words reach the consumer in fetch order. Each word carries its own address, and `cons_insn` equals the response data returned for that address.
- R4: The queue occupancy plus the outstanding requests never exceed `DEPTH` (8). With the consumer stalled, the block fills up to exactly `DEPTH` words and then stops issuing.
- R5: While `cons_valid` is high and `cons_ready` is low, with no redirect, `cons_valid`, `cons_addr` and `cons_insn` stay unchanged on the next cycle.
- R6: The cycle after a redirect, the queue is empty and the request address equals the redirect target. No request is issued in the redirect cycle.
- R7: When a redirect and `cons_ready` are high in the same cycle, the flush wins: `cons_valid` is low and no word is transferred.
- R8: The request tag flips on every redirect. No response to a request issued before a redirect reaches the consumer, and this holds for back-to-back redirects too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Jump taken: flush the queue and restart fetching |
| redir_target | input | ADDR_W | Word address to restart fetching from |
| mem_req_valid | output | 1 | A fetch request is issued this cycle |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_req_tag | output | 1 | Epoch bit sent with the request |
| mem_rsp_valid | input | 1 | A response is returned this cycle, in issue order |
| mem_rsp_tag | input | 1 | Epoch bit echoed from the matching request |
| mem_rsp_data | input | DATA_W | Instruction word returned |
| cons_valid | output | 1 | Head of the queue is available |
| cons_ready | input | 1 | Consumer takes the head word this cycle |
| cons_insn | output | DATA_W | Instruction word at the head |
| cons_addr | output | ADDR_W | Word address of the head instruction |

## Verification
A request shows on `mem_req_*` in the cycle it is allowed. An accepted response is visible at the consumer port one cycle after it is presented, so the earliest word after a redirect appears the memory latency plus two cycles after the redirect cycle. The bench drives inputs just after the rising edge and samples on the falling edge. A transfer seen at a falling edge is therefore the one the next rising edge commits, and redirect effects are checked at the falling edge of the redirect cycle (R7) and at the falling edge of the cycle after it (R6, R8). A scoreboard holds the addresses expected since the last redirect. The memory model checks the fetch stream and the occupancy bound on every request it sees.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int unsigned PFQ_ADDR_W = 16;
  localparam int unsigned PFQ_DATA_W = 32;
  localparam int unsigned PFQ_DEPTH  = 8;

  // width of a counter that must hold 0..n
  function automatic int unsigned pfq_cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned CNT_W     = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_target,
  input  logic [CNT_W-1:0]  occupancy,
  input  logic              rsp_valid,
  input  logic              rsp_tag,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_tag,
  output logic              rsp_keep,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [CNT_W-1:0]  inflight
);
  localparam logic [CNT_W:0] BUDGET = (CNT_W+1)'(DEPTH);

  logic [ADDR_W-1:0] pc_q, rsp_pc_q;
  logic              epoch_q;
  logic [CNT_W-1:0]  inflight_q, stale_q;
  logic [CNT_W:0]    used;

  assign used      = {1'b0, occupancy} + {1'b0, inflight_q};
  assign req_valid = !redir_valid && (used < BUDGET);
  assign req_addr  = pc_q;
  assign req_tag   = epoch_q;
  assign rsp_keep  = rsp_valid && !redir_valid && (stale_q == '0) && (rsp_tag == epoch_q);
  assign rsp_addr  = rsp_pc_q;
  assign inflight  = inflight_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q       <= RESET_VEC;
      rsp_pc_q   <= RESET_VEC;
      epoch_q    <= 1'b0;
      inflight_q <= '0;
      stale_q    <= '0;
    end else begin
      inflight_q <= inflight_q + CNT_W'(req_valid) - CNT_W'(rsp_valid);
      if (redir_valid) begin
        pc_q     <= redir_target;
        rsp_pc_q <= redir_target;
        epoch_q  <= ~epoch_q;
        stale_q  <= inflight_q - CNT_W'(rsp_valid);
      end else begin
        if (req_valid) pc_q <= pc_q + ADDR_W'(1);
        if (rsp_keep)  rsp_pc_q <= rsp_pc_q + ADDR_W'(1);
        if (rsp_valid && (stale_q != '0)) stale_q <= stale_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int unsigned WIDTH = 48,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign head_data = slots[rd_q];
  assign empty     = (cnt_q == '0);
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + PTR_W'(1);
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) slots[wr_q] <= push_data;
  end
endmodule

// File: rtl/insn_prefetch_q.sv
module insn_prefetch_q
  import pfq_pkg::*;
#(
  parameter int unsigned ADDR_W = PFQ_ADDR_W,
  parameter int unsigned DATA_W = PFQ_DATA_W,
  parameter int unsigned DEPTH  = PFQ_DEPTH,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_target,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_tag,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_tag,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              cons_valid,
  input  logic              cons_ready,
  output logic [DATA_W-1:0] cons_insn,
  output logic [ADDR_W-1:0] cons_addr
);
  localparam int unsigned CNT_W = pfq_cnt_w(DEPTH);
  localparam int unsigned ENT_W = ADDR_W + DATA_W;

  logic              rsp_keep, q_empty, q_pop;
  logic [ADDR_W-1:0] rsp_addr;
  logic [CNT_W-1:0]  occupancy, inflight;
  logic [ENT_W-1:0]  head;

  pfq_fetch_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .RESET_VEC(RESET_VEC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_target(redir_target),
    .occupancy(occupancy),
    .rsp_valid(mem_rsp_valid), .rsp_tag(mem_rsp_tag),
    .req_valid(mem_req_valid), .req_addr(mem_req_addr), .req_tag(mem_req_tag),
    .rsp_keep(rsp_keep), .rsp_addr(rsp_addr), .inflight(inflight)
  );

  pfq_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(redir_valid),
    .push(rsp_keep), .push_data({rsp_addr, mem_rsp_data}),
    .pop(q_pop), .head_data(head), .empty(q_empty), .count(occupancy)
  );

  // a redirect hides the stale head so it cannot be taken
  assign cons_valid = !q_empty && !redir_valid;
  assign q_pop      = cons_valid && cons_ready;
  assign cons_addr  = head[ENT_W-1:DATA_W];
  assign cons_insn  = head[DATA_W-1:0];
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_target,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_req_tag,
  input logic              cons_valid,
  input logic              cons_ready,
  input logic [DATA_W-1:0] cons_insn,
  input logic [ADDR_W-1:0] cons_addr,
  input logic [CNT_W-1:0]  occupancy,
  input logic [CNT_W-1:0]  inflight
);
  // R4
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, occupancy} + {1'b0, inflight}) <= (CNT_W+1)'(DEPTH));

  // R2
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> mem_req_addr == $past(mem_req_addr) + ADDR_W'(1));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !cons_valid);

  // R6
  target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> mem_req_addr == $past(redir_target));

  // R8
  epoch_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> mem_req_tag != $past(mem_req_tag));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && !cons_ready) |=>
      (redir_valid || (cons_valid && $stable(cons_addr) && $stable(cons_insn))));

  // R3
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && cons_ready) |=>
      (!cons_valid || cons_addr == $past(cons_addr) + ADDR_W'(1)));
endmodule

bind insn_prefetch_q pfq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_pfq_chk (
  .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_target(redir_target),
  .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
  .cons_valid(cons_valid), .cons_ready(cons_ready), .cons_insn(cons_insn),
  .cons_addr(cons_addr), .occupancy(occupancy), .inflight(inflight)
);

// File: tb/insn_prefetch_q_bench.sv
module insn_prefetch_q_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam logic [AW-1:0] RST_VEC = 16'h0040;

  logic clk = 1'b0, rst_n = 1'b0;
  logic redir_valid = 1'b0;
  logic [AW-1:0] redir_target = '0;
  logic mem_req_valid, mem_req_tag;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_tag = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic cons_valid, cons_ready = 1'b0;
  logic [DW-1:0] cons_insn;
  logic [AW-1:0] cons_addr;

  insn_prefetch_q #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .RESET_VEC(RST_VEC)) u_insn_prefetch_q (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_target(redir_target),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
    .cons_valid(cons_valid), .cons_ready(cons_ready), .cons_insn(cons_insn), .cons_addr(cons_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  int cyc = 0, mem_lat = 2;
  int issued_new = 0, popped_new = 0;
  bit seq_break = 1'b1, r4_bad = 1'b0;
  logic [AW-1:0] prev_req = '0;
  logic last_tag = 1'b0;
  logic [AW-1:0] exp_q[$];
  logic [AW-1:0] mq_addr[$];
  logic mq_tag[$];
  int mq_due[$];

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // memory model: capture requests, answer in order after mem_lat cycles
  always @(negedge clk) begin
    if (rst_n && mem_req_valid) begin
      if (!seq_break) check(mem_req_addr == prev_req + 1'b1, "R2 sequential request", mem_req_addr, prev_req + 1'b1);
      seq_break = 1'b0;
      prev_req = mem_req_addr;
      last_tag = mem_req_tag;
      mq_addr.push_back(mem_req_addr);
      mq_tag.push_back(mem_req_tag);
      mq_due.push_back(cyc + mem_lat);
      issued_new++;
      if (issued_new - popped_new > DEPTH) r4_bad = 1'b1;
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (mq_due.size() > 0 && mq_due[0] <= cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_tag   = mq_tag.pop_front();
      mem_rsp_data  = word_of(mq_addr.pop_front());
      void'(mq_due.pop_front());
    end else begin
      mem_rsp_valid = 1'b0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cons_valid && cons_ready) begin
      popped_new++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R8 unexpected word", cons_addr, '0);
      end else begin
        logic [AW-1:0] e;
        e = exp_q.pop_front();
        check(cons_addr == e, "R3 address order", cons_addr, e);
        check(cons_insn == word_of(e), "R3 word data", cons_insn, word_of(e));
      end
    end
  end

  task automatic expect_run(input logic [AW-1:0] start, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(start + AW'(i));
  endtask

  task automatic drain();
    @(posedge clk); #1; cons_ready = 1'b1;
    while (exp_q.size() > 0) begin @(posedge clk); #1; end
    cons_ready = 1'b0;
  endtask

  task automatic redirect(input logic [AW-1:0] tgt, input bit with_ready);
    @(posedge clk); #1;
    redir_valid = 1'b1; redir_target = tgt; cons_ready = with_ready;
    exp_q.delete(); issued_new = 0; popped_new = 0; seq_break = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", cyc, '0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [AW-1:0] hold_addr, tgt;
    logic [DW-1:0] hold_insn;
    logic tag_before;
    repeat (4) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cons_valid == 1'b0, "R1 queue empty after reset", cons_valid, 0);
    check(mem_req_valid == 1'b1 && mem_req_addr == RST_VEC, "R1 first request at reset vector", mem_req_addr, RST_VEC);
    check(mem_req_tag == 1'b0, "R1 epoch starts at 0", mem_req_tag, 0);

    // R2, R3: plain stream
    expect_run(RST_VEC, 12);
    drain();

    // R4, R5: consumer stalled, queue fills to depth
    repeat (30) @(posedge clk);
    @(negedge clk);
    hold_addr = cons_addr; hold_insn = cons_insn;
    check(cons_valid && cons_addr == RST_VEC + 16'd12, "R5 head valid under stall", cons_addr, RST_VEC + 16'd12);
    check(issued_new - popped_new == DEPTH, "R4 fills exactly to depth", issued_new - popped_new, DEPTH);
    check(mem_req_valid == 1'b0, "R4 no request when full", mem_req_valid, 0);
    repeat (5) @(negedge clk);
    check(cons_valid && cons_addr == hold_addr && cons_insn == hold_insn, "R5 head stable", cons_insn, hold_insn);
    expect_run(RST_VEC + 16'd12, 10);
    drain();

    // R6, R7, R8: redirect into a full queue, ready high in the same cycle
    repeat (25) @(posedge clk);
    tag_before = last_tag;
    tgt = RST_VEC + 16'd22 + 16'd100;
    redirect(tgt, 1'b1);
    @(negedge clk);
    check(cons_valid == 1'b0, "R7 flush wins over pop", cons_valid, 0);
    check(mem_req_valid == 1'b0, "R6 no request in redirect cycle", mem_req_valid, 0);
    @(posedge clk); #1; redir_valid = 1'b0; cons_ready = 1'b0;
    @(negedge clk);
    check(cons_valid == 1'b0, "R6 queue empty after redirect", cons_valid, 0);
    check(mem_req_valid && mem_req_addr == tgt, "R6 restart at target", mem_req_addr, tgt);
    check(mem_req_tag != tag_before, "R8 tag flips", mem_req_tag, ~tag_before);
    expect_run(tgt, 10);
    drain();

    // R8: redirect with requests in flight, then a second redirect at once
    mem_lat = 4;
    expect_run(tgt + 16'd10, 30);
    @(posedge clk); #1; cons_ready = 1'b1;
    repeat (6) @(posedge clk);
    redirect(16'h0300, 1'b1);
    @(posedge clk); #1; redir_target = 16'h0500;
    @(posedge clk); #1; redir_valid = 1'b0;
    @(negedge clk);
    check(cons_valid == 1'b0, "R6 empty after double redirect", cons_valid, 0);
    check(mem_req_addr == 16'h0500, "R6 second target used", mem_req_addr, 16'h0500);
    expect_run(16'h0500, 16);
    while (exp_q.size() > 0) begin @(posedge clk); #1; end
    cons_ready = 1'b0;

    // R8: single redirect mid-stream, stale replies in flight
    mem_lat = 3;
    expect_run(16'h0510, 20);
    @(posedge clk); #1; cons_ready = 1'b1;
    repeat (4) @(posedge clk);
    redirect(16'h0A00, 1'b1);
    @(posedge clk); #1; redir_valid = 1'b0;
    expect_run(16'h0A00, 12);
    while (exp_q.size() > 0) begin @(posedge clk); #1; end
    cons_ready = 1'b0;
    repeat (10) @(negedge clk);
    check(cons_valid == 1'b1 && cons_addr == 16'h0A0C, "R8 only new-epoch words remain", cons_addr, 16'h0A0C);
    check(r4_bad == 1'b0, "R4 bound over whole run", r4_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule